// File: doc/BRIEF.md
# Configurable PLD I/O Macrocell

This block is one input/output logic cell of a sum-of-products programmable logic device. The product-term AND array lies outside the cell. The cell receives the product terms that belong to it, split into universal and regional groups. It ORs these terms into three sum terms, labelled A, B and C. A static merge setting can fold B into another sum term, or fold all three into one. The resulting sums feed two registers, Q1 and Q2, and one combinational term. Each register can act as a D or a T flip-flop. Each has its own asynchronous preset and reset terms. Each takes its clock either from a product term alone or from the quadrant register-clock pin ANDed with that product term.

The pin is driven by Q1 or by the combinational term, and a single universal term enables the driver. All feedback paths into the array are always available: Q1 and Q2 in true and complemented form, the combinational term, and the pin value. Because of this, Q1 can drive the pin while the combinational term feeds back. The pin value can pass straight into the array, or it can pass through an input latch clocked by the quadrant latch-clock pin.

The cell works on a fast system clock `clk`. It detects edges on the register and latch clocks by sampling them on `clk`. Configuration inputs are static and change only while `rst_n` is low.

Top module: `pld_io_cell`

## Requirements
- R1: `cfg_merge` selects how sums feed the logic. In encoding 0, Q1 takes A (4 terms), the combinational term is B (5 terms) and Q2 takes C (4 terms). In encoding 1, Q1 takes A|B (9 terms), Q2 takes C and the combinational term is 0. In encoding 2, Q2 takes B|C (9 terms), Q1 takes A and the combinational term is 0. In encoding 3, Q1 takes A|B|C (13 terms), and Q2's input and the combinational term are both 0.
- R2: A register in D mode (`cfg_tN`=0) loads its sum on a register-clock rising edge. Without such an edge it holds its value.
- R3: A register in T mode (`cfg_tN`=1) inverts its value on a register-clock rising edge when its sum is 1, and holds its value when the sum is 0.
- R4: With `cfg_syncN`=1, the register clock is `rclk_pin` AND the register's clock term. With `cfg_syncN`=0, it is the clock term alone. A rising edge is a `clk` sample at 1 after a sample at 0, and the sample value is 0 during reset.
- R5: Asynchronous reset forces a register output to 0 and preset forces it to 1, both combinationally and without a clock edge. Reset wins when both are asserted, and either one blocks a clock edge in that cycle. Q1 uses `q1_ap_u`/`q1_ar_u`. Q2 uses `q2_ap_r`/`q2_ar_u`.
- R6: `pin_out` is Q1 when `cfg_out_q1`=1 and the combinational term otherwise. `pin_oe` follows `oe_u`.
- R7: `fb_q1_n` and `fb_q2_n` are the complements of `fb_q1` and `fb_q2`. `fb_comb` always carries the combinational term.
- R8: With `cfg_latch_en`=0, `fb_pin` equals `pin_in`. With `cfg_latch_en`=1, `fb_pin` equals `pin_in` while `lclk_pin` is 0. While `lclk_pin` is 1, it holds the value sampled at the last `clk` edge at which `lclk_pin` was 0.
- R9: `rst_n` low clears both registers and the latch to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low power-up clear |
| pa_u | input | A_U | Universal terms of sum A |
| pa_r | input | A_R | Regional terms of sum A |
| pb_u | input | B_U | Universal terms of sum B |
| pb_r | input | B_R | Regional terms of sum B |
| pc_u | input | C_U | Universal terms of sum C |
| pc_r | input | C_R | Regional terms of sum C |
| q1_ap_u | input | 1 | Q1 asynchronous preset term |
| q1_ar_u | input | 1 | Q1 asynchronous reset term |
| q1_ck_u | input | 1 | Q1 clock term |
| q2_ap_r | input | 1 | Q2 asynchronous preset term (regional) |
| q2_ar_u | input | 1 | Q2 asynchronous reset term |
| q2_ck_u | input | 1 | Q2 clock term |
| oe_u | input | 1 | Output-enable term |
| rclk_pin | input | 1 | Quadrant register clock pin |
| lclk_pin | input | 1 | Quadrant latch clock pin |
| pin_in | input | 1 | Value seen on the I/O pin |
| cfg_merge | input | 2 | Sum merge encoding |
| cfg_t1 | input | 1 | Q1 is T type |
| cfg_t2 | input | 1 | Q2 is T type |
| cfg_sync1 | input | 1 | Q1 clock gated by pin |
| cfg_sync2 | input | 1 | Q2 clock gated by pin |
| cfg_out_q1 | input | 1 | Pin driven by Q1 |
| cfg_latch_en | input | 1 | Input latch in path |
| pin_out | output | 1 | Pin drive value |
| pin_oe | output | 1 | Pin driver enable |
| fb_q1 | output | 1 | Q1 feedback |
| fb_q1_n | output | 1 | Q1 complement feedback |
| fb_q2 | output | 1 | Q2 feedback |
| fb_q2_n | output | 1 | Q2 complement feedback |
| fb_comb | output | 1 | Combinational term feedback |
| fb_pin | output | 1 | Pin feedback, latched or direct |

## Verification
The assertions check four things on every cycle. A register in D mode loads its sum on a detected edge. A register in T mode changes state when it toggles. A register with no edge and no async term holds its value. An asserted reset term leaves its register at 0 one cycle later. The latch assertion checks that the held value stays frozen while the latch clock is high. Merge routing, pin selection, the complement feedback, reset priority over preset and transparent-latch flow come from static configuration. Only the bench scenarios can show these, because they compare every output against the reference model under each configuration.

// File: rtl/pld_io_cell.sv
module pld_io_cell #(
  parameter int A_U = 1,
  parameter int A_R = 3,
  parameter int B_U = 2,
  parameter int B_R = 3,
  parameter int C_U = 1,
  parameter int C_R = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [A_U-1:0] pa_u,
  input  logic [A_R-1:0] pa_r,
  input  logic [B_U-1:0] pb_u,
  input  logic [B_R-1:0] pb_r,
  input  logic [C_U-1:0] pc_u,
  input  logic [C_R-1:0] pc_r,
  input  logic           q1_ap_u,
  input  logic           q1_ar_u,
  input  logic           q1_ck_u,
  input  logic           q2_ap_r,
  input  logic           q2_ar_u,
  input  logic           q2_ck_u,
  input  logic           oe_u,
  input  logic           rclk_pin,
  input  logic           lclk_pin,
  input  logic           pin_in,
  input  logic [1:0]     cfg_merge,
  input  logic           cfg_t1,
  input  logic           cfg_t2,
  input  logic           cfg_sync1,
  input  logic           cfg_sync2,
  input  logic           cfg_out_q1,
  input  logic           cfg_latch_en,
  output logic           pin_out,
  output logic           pin_oe,
  output logic           fb_q1,
  output logic           fb_q1_n,
  output logic           fb_q2,
  output logic           fb_q2_n,
  output logic           fb_comb,
  output logic           fb_pin
);

  localparam logic [1:0] M_SPLIT = 2'd0;
  localparam logic [1:0] M_B_TO_1 = 2'd1;
  localparam logic [1:0] M_B_TO_2 = 2'd2;
  localparam logic [1:0] M_ALL_TO_1 = 2'd3;

  logic sum_a, sum_b, sum_c;
  logic d1, d2, comb;
  logic ck1, ck2, ck1_prev, ck2_prev, rise1, rise2;
  logic q1_r, q2_r, hold;

  assign sum_a = (|pa_u) | (|pa_r);
  assign sum_b = (|pb_u) | (|pb_r);
  assign sum_c = (|pc_u) | (|pc_r);

  always_comb begin
    d1 = sum_a;
    d2 = sum_c;
    comb = 1'b0;
    case (cfg_merge)
      M_SPLIT:    comb = sum_b;
      M_B_TO_1:   d1 = sum_a | sum_b;
      M_B_TO_2:   d2 = sum_b | sum_c;
      M_ALL_TO_1: begin
        d1 = sum_a | sum_b | sum_c;
        d2 = 1'b0;
      end
      default:    comb = sum_b;
    endcase
  end

  assign ck1 = cfg_sync1 ? (rclk_pin & q1_ck_u) : q1_ck_u;
  assign ck2 = cfg_sync2 ? (rclk_pin & q2_ck_u) : q2_ck_u;
  assign rise1 = ck1 & ~ck1_prev;
  assign rise2 = ck2 & ~ck2_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck1_prev <= 1'b0;
      ck2_prev <= 1'b0;
      q1_r     <= 1'b0;
      q2_r     <= 1'b0;
      hold     <= 1'b0;
    end else begin
      ck1_prev <= ck1;
      ck2_prev <= ck2;
      if (q1_ar_u)      q1_r <= 1'b0;
      else if (q1_ap_u) q1_r <= 1'b1;
      else if (rise1)   q1_r <= cfg_t1 ? (q1_r ^ d1) : d1;
      if (q2_ar_u)      q2_r <= 1'b0;
      else if (q2_ap_r) q2_r <= 1'b1;
      else if (rise2)   q2_r <= cfg_t2 ? (q2_r ^ d2) : d2;
      if (!lclk_pin)    hold <= pin_in;
    end
  end

  assign fb_q1   = q1_ar_u ? 1'b0 : (q1_ap_u ? 1'b1 : q1_r);
  assign fb_q2   = q2_ar_u ? 1'b0 : (q2_ap_r ? 1'b1 : q2_r);
  assign fb_q1_n = ~fb_q1;
  assign fb_q2_n = ~fb_q2;
  assign fb_comb = comb;
  assign pin_out = cfg_out_q1 ? fb_q1 : comb;
  assign pin_oe  = oe_u;
  assign fb_pin  = (cfg_latch_en && lclk_pin) ? hold : pin_in;

  p_dload_q1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_t1 && rise1 && !q1_ar_u && !q1_ap_u) |=> (q1_r == $past(d1)));

  p_hold_q2_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise2 && !q2_ar_u && !q2_ap_r) |=> (q2_r == $past(q2_r)));

  p_toggle_q1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_t1 && rise1 && d1 && !q1_ar_u && !q1_ap_u) |=> (q1_r != $past(q1_r)));

  p_clear_q2_r5: assert property (@(posedge clk) disable iff (!rst_n)
    q2_ar_u |=> !q2_r);

  p_latch_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lclk_pin |=> $stable(hold));

endmodule

// File: tb/pld_io_cell_test.sv
module pld_io_cell_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [0:0] pa_u;
  logic [2:0] pa_r;
  logic [1:0] pb_u;
  logic [2:0] pb_r;
  logic [0:0] pc_u;
  logic [2:0] pc_r;
  logic q1_ap_u, q1_ar_u, q1_ck_u, q2_ap_r, q2_ar_u, q2_ck_u, oe_u;
  logic rclk_pin, lclk_pin, pin_in;
  logic [1:0] cfg_merge;
  logic cfg_t1, cfg_t2, cfg_sync1, cfg_sync2, cfg_out_q1, cfg_latch_en;
  logic pin_out, pin_oe, fb_q1, fb_q1_n, fb_q2, fb_q2_n, fb_comb, fb_pin;

  int checks = 0;
  int errors = 0;
  string tag = "R9";

  always #10 clk = ~clk;

  pld_io_cell uut (
    .clk(clk), .rst_n(rst_n),
    .pa_u(pa_u), .pa_r(pa_r), .pb_u(pb_u), .pb_r(pb_r), .pc_u(pc_u), .pc_r(pc_r),
    .q1_ap_u(q1_ap_u), .q1_ar_u(q1_ar_u), .q1_ck_u(q1_ck_u),
    .q2_ap_r(q2_ap_r), .q2_ar_u(q2_ar_u), .q2_ck_u(q2_ck_u), .oe_u(oe_u),
    .rclk_pin(rclk_pin), .lclk_pin(lclk_pin), .pin_in(pin_in),
    .cfg_merge(cfg_merge), .cfg_t1(cfg_t1), .cfg_t2(cfg_t2),
    .cfg_sync1(cfg_sync1), .cfg_sync2(cfg_sync2),
    .cfg_out_q1(cfg_out_q1), .cfg_latch_en(cfg_latch_en),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb_q1(fb_q1), .fb_q1_n(fb_q1_n),
    .fb_q2(fb_q2), .fb_q2_n(fb_q2_n), .fb_comb(fb_comb), .fb_pin(fb_pin)
  );

  // reference state
  bit m_q1, m_q2, m_c1, m_c2, m_hold;

  function automatic bit any_set(int n);
    return n > 0;
  endfunction

  function automatic int cnt_a();
    return $countones(pa_u) + $countones(pa_r);
  endfunction
  function automatic int cnt_b();
    return $countones(pb_u) + $countones(pb_r);
  endfunction
  function automatic int cnt_c();
    return $countones(pc_u) + $countones(pc_r);
  endfunction

  // R1: merge map
  function automatic bit exp_d1();
    if (cfg_merge == 2'd3) return any_set(cnt_a() + cnt_b() + cnt_c());
    if (cfg_merge == 2'd1) return any_set(cnt_a() + cnt_b());
    return any_set(cnt_a());
  endfunction
  function automatic bit exp_d2();
    if (cfg_merge == 2'd3) return 1'b0;
    if (cfg_merge == 2'd2) return any_set(cnt_b() + cnt_c());
    return any_set(cnt_c());
  endfunction
  function automatic bit exp_comb();
    return (cfg_merge == 2'd0) ? any_set(cnt_b()) : 1'b0;
  endfunction

  function automatic bit forced(bit clr, bit set, bit state);
    if (clr) return 1'b0;
    if (set) return 1'b1;
    return state;
  endfunction

  function automatic bit next_q(bit clr, bit set, bit edge_seen, bit tmode, bit d, bit state);
    if (clr) return 1'b0;
    if (set) return 1'b1;
    if (!edge_seen) return state;
    if (tmode) return d ? !state : state;
    return d;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q1 <= 0; m_q2 <= 0; m_c1 <= 0; m_c2 <= 0; m_hold <= 0;
    end else begin
      bit c1, c2;
      c1 = cfg_sync1 ? (rclk_pin && q1_ck_u) : q1_ck_u;
      c2 = cfg_sync2 ? (rclk_pin && q2_ck_u) : q2_ck_u;
      m_q1 <= next_q(q1_ar_u, q1_ap_u, c1 && !m_c1, cfg_t1, exp_d1(), m_q1);
      m_q2 <= next_q(q2_ar_u, q2_ap_r, c2 && !m_c2, cfg_t2, exp_d2(), m_q2);
      m_c1 <= c1;
      m_c2 <= c2;
      if (!lclk_pin) m_hold <= pin_in;
    end
  end

  task automatic check(string what, string req, bit got, bit exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit e1, e2, ec;
    e1 = forced(q1_ar_u, q1_ap_u, m_q1);
    e2 = forced(q2_ar_u, q2_ap_r, m_q2);
    ec = exp_comb();
    check("fb_q1", tag, fb_q1, e1);
    check("fb_q2", tag, fb_q2, e2);
    check("fb_q1_n", {tag, " R7"}, fb_q1_n, !e1);
    check("fb_q2_n", {tag, " R7"}, fb_q2_n, !e2);
    check("fb_comb", {tag, " R7"}, fb_comb, ec);
    check("pin_out", {tag, " R6"}, pin_out, cfg_out_q1 ? e1 : ec);
    check("pin_oe", {tag, " R6"}, pin_oe, oe_u);
    check("fb_pin", {tag, " R8"}, fb_pin,
          (cfg_latch_en && lclk_pin) ? m_hold : pin_in);
  endtask

  function automatic bit sparse(int pct);
    return ($urandom % 100) < pct;
  endfunction

  task automatic drive_quiet();
    pa_u = '0; pa_r = '0; pb_u = '0; pb_r = '0; pc_u = '0; pc_r = '0;
    q1_ap_u = 0; q1_ar_u = 0; q1_ck_u = 0; q2_ap_r = 0; q2_ar_u = 0; q2_ck_u = 0;
    oe_u = 0; rclk_pin = 0; lclk_pin = 0; pin_in = 0;
  endtask

  task automatic drive_random(int async_pct);
    foreach (pa_u[i]) pa_u[i] = sparse(15);
    foreach (pa_r[i]) pa_r[i] = sparse(15);
    foreach (pb_u[i]) pb_u[i] = sparse(15);
    foreach (pb_r[i]) pb_r[i] = sparse(15);
    foreach (pc_u[i]) pc_u[i] = sparse(15);
    foreach (pc_r[i]) pc_r[i] = sparse(15);
    q1_ap_u = sparse(async_pct); q1_ar_u = sparse(async_pct);
    q2_ap_r = sparse(async_pct); q2_ar_u = sparse(async_pct);
    q1_ck_u = sparse(60); q2_ck_u = sparse(60);
    rclk_pin = sparse(50); lclk_pin = sparse(40);
    pin_in = sparse(50); oe_u = sparse(50);
  endtask

  // R9: reset with new static configuration
  task automatic start_phase(bit [1:0] mg, bit t1, bit t2, bit s1, bit s2, bit oq, bit le);
    @(negedge clk);
    rst_n = 0;
    drive_quiet();
    cfg_merge = mg; cfg_t1 = t1; cfg_t2 = t2; cfg_sync1 = s1; cfg_sync2 = s2;
    cfg_out_q1 = oq; cfg_latch_en = le;
    @(negedge clk);
    tag = "R9";
    compare_all();
    rst_n = 1;
  endtask

  task automatic run(string t, int cycles, int async_pct);
    tag = t;
    for (int k = 0; k < cycles; k++) begin
      drive_random(async_pct);
      @(negedge clk);
      compare_all();
    end
  endtask

  bit finished = 0;

  initial begin
    drive_quiet();
    cfg_merge = 0; cfg_t1 = 0; cfg_t2 = 0; cfg_sync1 = 1; cfg_sync2 = 1;
    cfg_out_q1 = 0; cfg_latch_en = 0;
    repeat (2) @(negedge clk);
    tag = "R9";
    compare_all();

    start_phase(2'd0, 0, 0, 1, 1, 0, 0); run("R2", 400, 0);
    start_phase(2'd0, 1, 1, 1, 1, 0, 0); run("R3", 400, 0);
    start_phase(2'd0, 1, 0, 0, 0, 1, 0); run("R4", 400, 0);
    start_phase(2'd0, 0, 1, 1, 0, 1, 0); run("R5", 400, 25);
    for (int m = 1; m < 4; m++) begin
      start_phase(m[1:0], 0, 0, 1, 1, 0, 0); run("R1", 300, 0);
      start_phase(m[1:0], 1, 1, 0, 1, 1, 0); run("R1", 300, 5);
    end
    start_phase(2'd0, 0, 1, 1, 1, 1, 0); run("R6", 400, 5);
    start_phase(2'd2, 1, 0, 0, 1, 0, 1); run("R8", 600, 5);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule